// File: doc/BRIEF.md
# Sequential Radix-2 Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor of the same width and yields one quotient bit per clock. It keeps a signed partial remainder one bit wider than the operands, and a combined dividend/quotient shift register. Each iteration moves the pair one place left and then subtracts the divisor from the partial remainder, or adds it. A mode input, sampled with the operands, picks one of two algorithms. In the restoring algorithm a negative difference is undone in the same cycle. In the non-restoring algorithm the sign left by the previous iteration decides whether the next one adds or subtracts, and a single correction cycle at the end brings a negative remainder back into range.

A request is a one-cycle `start_i` while the block is idle. `busy_o` stays high through the iterations and the correction cycle. `done_o` then pulses for one cycle, and the quotient and remainder stay on the outputs until the next accepted request. Both modes have the same fixed latency. A zero divisor sets `div_zero_o` and completes the handshake normally, but the quotient and remainder it reports carry no meaning.

Top module: `radix2_divider`

## Requirements
- R1: While reset is asserted, and once it is released, `busy_o`, `done_o`, `div_zero_o`, `quot_o` and `rem_o` are all 0. Reset takes effect at once, even in the middle of a division.
- R2: A `start_i` that is high while the block is idle is accepted. Count that cycle as cycle 0. `busy_o` is high from cycle 1 through cycle WIDTH+1, and `done_o` is high in cycle WIDTH+2 only. Both modes have this latency.
- R3: With `nonrest_i` = 0 (restoring) and a nonzero divisor, `quot_o` = floor(dividend / divisor) and `rem_o` = dividend mod divisor.
- R4: With `nonrest_i` = 1 (non-restoring) and a nonzero divisor, the results are the same as in R3, including the final correction of a negative remainder.
- R5: At WIDTH = 8, dividing 14 by 3 gives quotient 4 and remainder 2 in both modes.
- R6: A zero divisor sets `div_zero_o` = 1 while `done_o` is high. The latency is the one in R2. The next request with a nonzero divisor clears the flag.
- R7: A `start_i` seen while `busy_o` or `done_o` is high is ignored. It does not change the running division or its result, and it does not start a new one.
- R8: After `done_o`, `quot_o`, `rem_o` and `div_zero_o` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request a division; accepted only while idle |
| nonrest_i | input | 1 | Algorithm select: 0 restoring, 1 non-restoring; sampled with start |
| dividend_i | input | WIDTH | Unsigned dividend, sampled with start |
| divisor_i | input | WIDTH | Unsigned divisor, sampled with start |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Divisor of the last accepted request was zero |
| quot_o | output | WIDTH | Quotient |
| rem_o | output | WIDTH | Remainder |

## Verification
Two events can fall in the same cycle: the completion pulse and a fresh request. A new `start_i` can also arrive while the iterations are still running. The bench raises `start_i` with different operands in the very cycle where `done_o` is high, and again in the middle of a run. It then judges at the ports. In the cycle that follows, `busy_o` must stay low and the finished result must stay unchanged. The interrupted run must still finish with its own quotient and remainder, at the latency given in R2.

// File: rtl/radix2_div_pkg.sv
package radix2_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } div_state_e;
endpackage

// File: rtl/radix2_div_rstsync.sv
module radix2_div_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/radix2_div_ctrl.sv
module radix2_div_ctrl
  import radix2_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  div_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RUN;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
        else               cnt_d   = cnt_q + 1'b1;
      end
      ST_FIX:  state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_RUN);
  assign fix_o    = (state_q == ST_FIX);
  assign busy_o   = (state_q == ST_RUN) || (state_q == ST_FIX);
  assign done_o   = (state_q == ST_DONE);

  // R2: the completion pulse lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R2: the iteration counter never runs past the operand width
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (cnt_q < CW'(WIDTH)));
  // R2: the correction cycle is followed by the completion pulse
  a_r2_fix_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    fix_o |=> done_o);
  // R7: a request during the completion pulse does not raise busy
  a_r7_no_restart_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> !busy_o);
endmodule

// File: rtl/radix2_div_step.sv
module radix2_div_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   p_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             nonrest_i,
  output logic [WIDTH:0]   p_o,
  output logic [WIDTH-1:0] a_o
);
  localparam int XW = WIDTH + 2;

  logic [XW-1:0] shifted, b_ext, sum;
  logic do_sub, neg, restore;

  always_comb begin
    shifted = {p_i, a_i[WIDTH-1]};
    b_ext   = {2'b00, b_i};
    do_sub  = nonrest_i ? !p_i[WIDTH] : 1'b1;
    sum     = do_sub ? (shifted - b_ext) : (shifted + b_ext);
    neg     = sum[XW-1];
    restore = !nonrest_i && neg;
    p_o     = restore ? shifted[WIDTH:0] : sum[WIDTH:0];
    a_o     = {a_i[WIDTH-2:0], !neg};
  end
endmodule

// File: rtl/radix2_divider.sv
module radix2_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             nonrest_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_zero_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o
);
  logic rst_sync_n;
  logic accept, step_en, fix_en;

  logic [WIDTH:0]   p_q, p_d, step_p;
  logic [WIDTH-1:0] a_q, a_d, step_a;
  logic [WIDTH-1:0] b_q, b_d;
  logic             mode_q, mode_d;
  logic             dz_q, dz_d;
  logic             reg_en;

  radix2_div_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  radix2_div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_i),
    .accept_o (accept),
    .step_o   (step_en),
    .fix_o    (fix_en),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  radix2_div_step #(.WIDTH(WIDTH)) u_step (
    .p_i       (p_q),
    .a_i       (a_q),
    .b_i       (b_q),
    .nonrest_i (mode_q),
    .p_o       (step_p),
    .a_o       (step_a)
  );

  always_comb begin
    p_d    = p_q;
    a_d    = a_q;
    b_d    = b_q;
    mode_d = mode_q;
    dz_d   = dz_q;
    reg_en = accept || step_en || fix_en;
    if (accept) begin
      p_d    = '0;
      a_d    = dividend_i;
      b_d    = divisor_i;
      mode_d = nonrest_i;
      dz_d   = (divisor_i == '0);
    end else if (step_en) begin
      p_d = step_p;
      a_d = step_a;
    end else if (fix_en) begin
      if (p_q[WIDTH]) p_d = p_q + {1'b0, b_q};
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      p_q    <= '0;
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (reg_en) begin
      p_q    <= p_d;
      a_q    <= a_d;
      b_q    <= b_d;
      mode_q <= mode_d;
      dz_q   <= dz_d;
    end
  end

  assign quot_o     = a_q;
  assign rem_o      = p_q[WIDTH-1:0];
  assign div_zero_o = dz_q;

  // R3: a reported remainder is always below the divisor
  a_r3_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_o && !div_zero_o) |-> (rem_o < b_q));
  // R4: the correction leaves no negative remainder behind
  a_r4_rem_nonneg: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |-> !p_q[WIDTH]);
  // R8: results stay put after the completion pulse
  a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_o |=> ($stable(quot_o) && $stable(rem_o) && $stable(div_zero_o)));
  // R2: busy and done are never high together
  a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(busy_o && done_o));
endmodule

// File: tb/radix2_divider_test.sv
module radix2_divider_test;
  localparam int W = 8;
  localparam int LAT = W + 2;
  localparam int NV = 10;

  localparam logic [W-1:0] T_A [NV] = '{8'd14, 8'd255, 8'd255, 8'd0,  8'd200, 8'd7, 8'd128, 8'd250, 8'd99,  8'd255};
  localparam logic [W-1:0] T_B [NV] = '{8'd3,  8'd1,   8'd255, 8'd7,  8'd13,  8'd9, 8'd2,   8'd17,  8'd100, 8'd16};
  localparam logic [W-1:0] T_Q [NV] = '{8'd4,  8'd255, 8'd1,   8'd0,  8'd15,  8'd0, 8'd64,  8'd14,  8'd0,   8'd15};
  localparam logic [W-1:0] T_R [NV] = '{8'd2,  8'd0,   8'd0,   8'd0,  8'd5,   8'd7, 8'd0,   8'd12,  8'd99,  8'd15};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic busy, done, dz;
  logic [W-1:0] quot, rem;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  radix2_divider #(.WIDTH(W)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .nonrest_i  (mode),
    .dividend_i (dvd),
    .divisor_i  (dvs),
    .busy_o     (busy),
    .done_o     (done),
    .div_zero_o (dz),
    .quot_o     (quot),
    .rem_o      (rem)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where done is seen
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic m,
                         output int lat, output logic busy1);
    start = 1'b1; dvd = a; dvs = b; mode = m;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busy1 = busy;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic b1;
    logic [W-1:0] q0, r0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !dz && quot == 0 && rem == 0, "R1 during reset", {busy, done, dz}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !dz && quot == 0 && rem == 0, "R1 after release", {busy, done, dz}, 0);

    // table walk, both modes: R3, R4, R5
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < NV; i++) begin
        run_div(T_A[i], T_B[i], m[0], lat, b1);
        chk(quot == T_Q[i], m == 0 ? "R3 quotient" : "R4 quotient", quot, T_Q[i]);
        chk(rem == T_R[i],  m == 0 ? "R3 remainder" : "R4 remainder", rem, T_R[i]);
        if (i == 0) chk(quot == 4 && rem == 2, "R5 14/3", quot * 16 + rem, 66);
        chk(lat == LAT && b1, "R2 latency", lat, LAT);
        chk(!dz, "R6 flag clear", dz, 0);
        @(negedge clk);
        chk(!done && !busy, "R2 single done", done, 0);
      end
    end

    // R6: zero divisor
    run_div(8'd77, 8'd0, 1'b0, lat, b1);
    chk(dz == 1'b1, "R6 flag set restoring", dz, 1);
    chk(lat == LAT, "R6 latency", lat, LAT);
    @(negedge clk);
    run_div(8'd77, 8'd0, 1'b1, lat, b1);
    chk(dz == 1'b1 && lat == LAT, "R6 flag set non-restoring", dz, 1);
    @(negedge clk);
    chk(dz == 1'b1, "R8 flag held", dz, 1);
    run_div(8'd9, 8'd4, 1'b1, lat, b1);
    chk(!dz && quot == 2 && rem == 1, "R6 flag cleared", quot, 2);

    // R7: request during the completion pulse
    start = 1'b1; dvd = 8'd50; dvs = 8'd5; mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R7 start on done busy", busy, 0);
    chk(quot == 2 && rem == 1, "R7 start on done result", quot, 2);

    // R8: results hold while idle
    repeat (5) @(negedge clk);
    chk(quot == 2 && rem == 1 && !dz, "R8 hold", quot, 2);

    // R7: request in the middle of a run
    start = 1'b1; dvd = 8'd20; dvs = 8'd3; mode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; dvd = 8'd100; dvs = 8'd7; mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(quot == 6 && rem == 2, "R7 mid-run quotient", quot, 6);
    chk(lat == LAT, "R7 mid-run latency", lat, LAT);
    @(negedge clk);
    chk(!busy && !done, "R7 no restart", busy, 0);

    // R1: reset in the middle of a division
    q0 = quot; r0 = rem;
    start = 1'b1; dvd = 8'd200; dvs = 8'd9; mode = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!busy && !done && quot == 0 && rem == 0, "R1 async reset", quot, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !dz && q0 != 8'hEE && r0 != 8'hEE, "R1 idle after reset", busy, 0);
    run_div(8'd14, 8'd3, 1'b1, lat, b1);
    chk(quot == 4 && rem == 2 && lat == LAT, "R5 after reset", quot, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule